// File: doc/BRIEF.md
# Target Address Match and Event Tagger

This block is the target-side front end of a two-wire serial bus interface, working at byte level. A bus layer below it reports start and stop conditions and each received byte; the block compares the first byte after a start against a set of programmable 7-bit target addresses, each slot with its own enable bit. An address byte that hits an enabled slot is acknowledged. A byte that hits none is not acknowledged, and the rest of that transfer is ignored.

For a write aimed at this target, every byte goes out on a receive-queue push port as a 32-bit entry whose top two bits tag it as transfer start, data or transfer end. For a read aimed at this target, the block raises a read event and serves bytes to the bus layer from a one-byte transmit holding register. If that register is empty when a byte is needed, the request is held, which stretches the clock. A request that waits too long ends with a timeout code on the command status output.

Events are collected in sticky interrupt status bits. Writing 1 to a status bit clears it. A single interrupt line reports any status bit whose enable bit is set.

Top module: `tgt_match_tagger`

## Requirements
- R1: An address byte is the first byte after a start. Its bits 7:1 are compared with every slot. Slot k keeps its address in `cfg_addr` bits 8k+6:8k and its enable bit in bit 8k+7. On a hit with an enabled slot, `addr_ack` pulses for one cycle at the clock edge after the byte.
- R2: An address byte that matches no enabled slot gets no acknowledge. That byte and every later byte or stop, up to the next start, produce no queue push and set no status bit.
- R3: A matched address with bit 0 = 0 (write) pushes one entry at the same edge as the acknowledge. The entry holds tag 1 (start) in bits 31:30, the address byte in bits 7:0, and zeros elsewhere.
- R4: During a matched write, each later byte pushes an entry with tag 2 (data). A stop pushes an entry with tag 3 (end) and data 0x00. Every push sets receive-event status bit 24.
- R5: A matched address with bit 0 = 1 (read) sets read-event status bit 21 and pushes nothing.
- R6: `tx_load` fills the holding register, which drives `tx_busy` high. During a read, a `tx_req` finds the register either full or empty. If full, the byte appears on `tx_data` with a one-cycle `tx_valid` at the next edge, and `tx_busy` goes low. If empty, the request waits and is served one edge after the register is filled.
- R7: A `tx_req` that finds the holding register empty sets underrun status bit 22, but only after at least one byte has already been served in the current read. The first request of a read never sets it.
- R8: `cmd_status` is 0 (success) after reset and after every matched read address. It becomes 5 (stretch timeout) when a request has waited `STRETCH_LIMIT` cycles without a byte being loaded. The wait is then abandoned.
- R9: The `rxq_full` level sets status bit 26, and the `rxq_thld` level sets status bit 25. Both bits remain set after the input falls.
- R10: Writing 1 to a bit of `int_clr` clears that status bit. If a set event occurs in the same cycle, the set wins.
- R11: `irq` is high exactly when some status bit is 1 and its `int_en` bit, at the same position, is 1.
- R12: Reset clears all status bits, pulses, the holding register and `cmd_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | NUM_SLOTS*8 | Address slots, enable bit above each 7-bit address |
| int_en | input | 32 | Interrupt enable mask, same positions as status |
| int_clr | input | 32 | Write-1-to-clear strobe for status bits |
| bus_start | input | 1 | Start or repeated start seen on the bus |
| bus_stop | input | 1 | Stop seen on the bus |
| byte_valid | input | 1 | A received byte is on byte_data |
| byte_data | input | 8 | Received byte |
| rxq_full | input | 1 | Receive queue is full (level) |
| rxq_thld | input | 1 | Receive queue at or above threshold (level) |
| tx_load | input | 1 | Load tx_byte into the holding register |
| tx_byte | input | 8 | Byte to load |
| tx_req | input | 1 | Bus layer needs the next read byte |
| addr_ack | output | 1 | Address acknowledged (one-cycle pulse) |
| rxq_push | output | 1 | Push rxq_word into the receive queue |
| rxq_word | output | 32 | Tagged receive entry |
| tx_valid | output | 1 | tx_data holds a served byte (pulse) |
| tx_data | output | 8 | Served byte |
| tx_busy | output | 1 | Holding register is full |
| cmd_status | output | 3 | Target command status code |
| int_status | output | 32 | Sticky status bits 26:21 |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default four slots with one of them disabled. This places an enabled low slot, an enabled top slot and a disabled slot side by side in one table, so mismatches on slot position and enable bit both show up. `STRETCH_LIMIT` is reduced to 8 so that the stretch timeout, and its clearing by a fresh read address, happen within a few dozen cycles. Directed cases cover a load arriving while a request waits, and a set event colliding with a clear.

// File: rtl/tgt_pkg.sv
package tgt_pkg;

    localparam int SLOT_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_WRITE = 2'd2,
        ST_READ  = 2'd3
    } tgt_state_e;

    typedef enum logic [1:0] {
        TAG_EMPTY = 2'd0,
        TAG_START = 2'd1,
        TAG_DATA  = 2'd2,
        TAG_END   = 2'd3
    } rx_tag_e;

    // status bit positions; the struct below is packed MSB first so that
    // its bits line up with status bits 26 down to 21
    localparam int STAT_LO = 21;
    localparam int STAT_HI = 26;
    localparam int NSTAT   = STAT_HI - STAT_LO + 1;

    typedef struct packed {
        logic rx_full;    // 26
        logic rx_thld;    // 25
        logic rx_event;   // 24
        logic stop_busy;  // 23
        logic tx_undr;    // 22
        logic rd_event;   // 21
    } stat_set_t;

    localparam logic [2:0] CMD_OK         = 3'd0;
    localparam logic [2:0] CMD_STRETCH_TO = 3'd5;

    function automatic logic [31:0] rx_word(input rx_tag_e tag, input logic [7:0] d);
        return {tag, 22'd0, d};
    endfunction

endpackage

// File: rtl/tgt_addr_match.sv
module tgt_addr_match
    import tgt_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic [NUM_SLOTS*SLOT_W-1:0] cfg,
    input  logic [6:0]                  addr7,
    output logic                        hit
);
    logic [NUM_SLOTS-1:0] slot_hit;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign slot_hit[g] = cfg[g*SLOT_W + 7] && (cfg[g*SLOT_W +: 7] == addr7);
    end

    assign hit = |slot_hit;
endmodule

// File: rtl/tgt_tx_hold.sv
module tgt_tx_hold
    import tgt_pkg::*;
#(
    parameter int STRETCH_LIMIT = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic       xfer_begin,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       req,
    output logic       full,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       underrun,
    output logic [2:0] cmd_status
);
    localparam int CW = $clog2(STRETCH_LIMIT + 1);

    logic [7:0]  hold;
    logic        pending;
    logic        served_any;
    logic [CW-1:0] wait_cnt;
    logic        need;
    logic        serve;

    assign need     = req || pending;
    assign serve    = active && need && full;
    assign underrun = active && req && !full && served_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold       <= '0;
            full       <= 1'b0;
            pending    <= 1'b0;
            served_any <= 1'b0;
            wait_cnt   <= '0;
            out_valid  <= 1'b0;
            out_data   <= '0;
            cmd_status <= CMD_OK;
        end else begin
            out_valid <= 1'b0;
            if (serve) begin
                out_valid  <= 1'b1;
                out_data   <= hold;
                full       <= 1'b0;
                pending    <= 1'b0;
                served_any <= 1'b1;
                wait_cnt   <= '0;
            end else if (active && req) begin
                pending  <= 1'b1;
                wait_cnt <= '0;
            end else if (active && pending) begin
                if (wait_cnt == CW'(STRETCH_LIMIT - 1)) begin
                    pending    <= 1'b0;
                    cmd_status <= CMD_STRETCH_TO;
                end else begin
                    wait_cnt <= wait_cnt + 1'b1;
                end
            end else if (!active) begin
                pending <= 1'b0;
            end
            if (load) begin
                hold <= load_byte;
                full <= 1'b1;
            end
            if (xfer_begin) begin
                served_any <= 1'b0;
                pending    <= 1'b0;
                wait_cnt   <= '0;
                cmd_status <= CMD_OK;
            end
        end
    end
endmodule

// File: rtl/tgt_irq_status.sv
module tgt_irq_status
    import tgt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  stat_set_t        set,
    input  logic [NSTAT-1:0] clr,
    input  logic [NSTAT-1:0] en,
    output logic [NSTAT-1:0] stat,
    output logic             irq
);
    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= (stat & ~clr) | set;
    end

    assign irq = |(stat & en);
endmodule

// File: rtl/tgt_match_tagger.sv
module tgt_match_tagger
    import tgt_pkg::*;
#(
    parameter int NUM_SLOTS     = 4,
    parameter int STRETCH_LIMIT = 1000
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_SLOTS*SLOT_W-1:0] cfg_addr,
    input  logic [31:0]                 int_en,
    input  logic [31:0]                 int_clr,
    input  logic                        bus_start,
    input  logic                        bus_stop,
    input  logic                        byte_valid,
    input  logic [7:0]                  byte_data,
    input  logic                        rxq_full,
    input  logic                        rxq_thld,
    input  logic                        tx_load,
    input  logic [7:0]                  tx_byte,
    input  logic                        tx_req,
    output logic                        addr_ack,
    output logic                        rxq_push,
    output logic [31:0]                 rxq_word,
    output logic                        tx_valid,
    output logic [7:0]                  tx_data,
    output logic                        tx_busy,
    output logic [2:0]                  cmd_status,
    output logic [31:0]                 int_status,
    output logic                        irq
);
    tgt_state_e state, state_n;
    logic       hit;
    logic       ack_n, push_n, xfer_begin, stop_act, undr;
    rx_tag_e    tag_n;
    logic [7:0] data_n;
    stat_set_t  set;
    logic [NSTAT-1:0] stat;

    logic unused_bits;
    assign unused_bits = ^{int_en[31:STAT_HI+1], int_en[STAT_LO-1:0],
                           int_clr[31:STAT_HI+1], int_clr[STAT_LO-1:0]};

    tgt_addr_match #(.NUM_SLOTS(NUM_SLOTS)) u_match (
        .cfg   (cfg_addr),
        .addr7 (byte_data[7:1]),
        .hit   (hit)
    );

    always_comb begin
        state_n    = state;
        ack_n      = 1'b0;
        push_n     = 1'b0;
        tag_n      = TAG_EMPTY;
        data_n     = 8'd0;
        xfer_begin = 1'b0;
        stop_act   = 1'b0;
        if (bus_start) begin
            state_n = ST_ADDR;
        end else if (bus_stop) begin
            state_n = ST_IDLE;
            if (state == ST_WRITE) begin
                push_n = 1'b1;
                tag_n  = TAG_END;
            end
            stop_act = (state == ST_WRITE) || (state == ST_READ);
        end else if (byte_valid) begin
            unique case (state)
                ST_ADDR: begin
                    if (hit) begin
                        ack_n = 1'b1;
                        if (byte_data[0]) begin
                            state_n    = ST_READ;
                            xfer_begin = 1'b1;
                        end else begin
                            state_n = ST_WRITE;
                            push_n  = 1'b1;
                            tag_n   = TAG_START;
                            data_n  = byte_data;
                        end
                    end else begin
                        state_n = ST_IDLE;
                    end
                end
                ST_WRITE: begin
                    push_n = 1'b1;
                    tag_n  = TAG_DATA;
                    data_n = byte_data;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            addr_ack <= 1'b0;
            rxq_push <= 1'b0;
            rxq_word <= '0;
        end else begin
            state    <= state_n;
            addr_ack <= ack_n;
            rxq_push <= push_n;
            if (push_n) rxq_word <= rx_word(tag_n, data_n);
        end
    end

    tgt_tx_hold #(.STRETCH_LIMIT(STRETCH_LIMIT)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .active     (state == ST_READ),
        .xfer_begin (xfer_begin),
        .load       (tx_load),
        .load_byte  (tx_byte),
        .req        (tx_req),
        .full       (tx_busy),
        .out_valid  (tx_valid),
        .out_data   (tx_data),
        .underrun   (undr),
        .cmd_status (cmd_status)
    );

    always_comb begin
        set.rx_full   = rxq_full;
        set.rx_thld   = rxq_thld;
        set.rx_event  = push_n;
        set.stop_busy = stop_act;
        set.tx_undr   = undr;
        set.rd_event  = xfer_begin;
    end

    tgt_irq_status u_stat (
        .clk  (clk),
        .rst  (rst),
        .set  (set),
        .clr  (int_clr[STAT_HI:STAT_LO]),
        .en   (int_en[STAT_HI:STAT_LO]),
        .stat (stat),
        .irq  (irq)
    );

    assign int_status = {{(31-STAT_HI){1'b0}}, stat, {STAT_LO{1'b0}}};
endmodule

// File: rtl/tgt_match_tagger_chk.sv
module tgt_match_tagger_chk (
    input logic        clk,
    input logic        rst,
    input logic        tx_req,
    input logic        addr_ack,
    input logic        rxq_push,
    input logic [31:0] rxq_word,
    input logic        tx_valid,
    input logic        tx_busy,
    input logic [2:0]  cmd_status,
    input logic [31:0] int_status
);
    // R3/R4: every pushed entry carries a non-empty tag
    a_r4_push_tagged: assert property (@(posedge clk) disable iff (rst)
        rxq_push |-> rxq_word[31:30] != 2'd0);

    // R3: a start entry appears together with the acknowledge
    a_r3_start_acked: assert property (@(posedge clk) disable iff (rst)
        (rxq_push && rxq_word[31:30] == 2'd1) |-> addr_ack);

    // R6: a byte is served only out of a full holding register
    a_r6_serve_needs_byte: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(tx_busy));

    // R7: underrun status only rises after a transmit request
    a_r7_underrun_from_req: assert property (@(posedge clk) disable iff (rst)
        $rose(int_status[22]) |-> $past(tx_req));

    // R8: only the success and timeout codes are produced
    a_r8_status_codes: assert property (@(posedge clk) disable iff (rst)
        (cmd_status == 3'd0) || (cmd_status == 3'd5));
endmodule

bind tgt_match_tagger tgt_match_tagger_chk chk (
    .clk        (clk),
    .rst        (rst),
    .tx_req     (tx_req),
    .addr_ack   (addr_ack),
    .rxq_push   (rxq_push),
    .rxq_word   (rxq_word),
    .tx_valid   (tx_valid),
    .tx_busy    (tx_busy),
    .cmd_status (cmd_status),
    .int_status (int_status)
);

// File: tb/tb_tgt_match_tagger.sv
module tb_tgt_match_tagger;
    localparam int NUM_SLOTS = 4;
    localparam int STRETCH_LIMIT = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0] cfg_addr = 32'hFFB5_2290;
    logic [31:0] int_en = '0, int_clr = '0;
    logic bus_start = 0, bus_stop = 0, byte_valid = 0;
    logic [7:0] byte_data = '0;
    logic rxq_full = 0, rxq_thld = 0, tx_load = 0, tx_req = 0;
    logic [7:0] tx_byte = '0;
    logic addr_ack, rxq_push, tx_valid, tx_busy, irq;
    logic [31:0] rxq_word, int_status;
    logic [7:0] tx_data;
    logic [2:0] cmd_status;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tgt_match_tagger #(.NUM_SLOTS(NUM_SLOTS), .STRETCH_LIMIT(STRETCH_LIMIT)) dut (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .int_en(int_en), .int_clr(int_clr),
        .bus_start(bus_start), .bus_stop(bus_stop), .byte_valid(byte_valid),
        .byte_data(byte_data), .rxq_full(rxq_full), .rxq_thld(rxq_thld),
        .tx_load(tx_load), .tx_byte(tx_byte), .tx_req(tx_req),
        .addr_ack(addr_ack), .rxq_push(rxq_push), .rxq_word(rxq_word),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_busy(tx_busy),
        .cmd_status(cmd_status), .int_status(int_status), .irq(irq)
    );

    // address byte, expected ack, expected push
    localparam logic [9:0] VEC [6] = '{
        {8'h20, 1'b1, 1'b1},   // slot 0 write
        {8'h21, 1'b1, 1'b0},   // slot 0 read
        {8'h44, 1'b0, 1'b0},   // slot 1 disabled
        {8'h6A, 1'b1, 1'b1},   // slot 2 write
        {8'hFE, 1'b1, 1'b1},   // slot 3 write
        {8'h12, 1'b0, 1'b0}    // no slot
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic s, input logic p, input logic v, input logic [7:0] d);
        bus_start = s; bus_stop = p; byte_valid = v; byte_data = d;
        @(negedge clk);
        bus_start = 0; bus_stop = 0; byte_valid = 0;
    endtask

    task automatic idle();
        step(0, 0, 0, 8'h00);
    endtask

    task automatic clear_all();
        int_clr = '1; idle(); int_clr = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12 reset state
        check("R12 status", int_status, 32'h0);
        check("R12 irq", {31'b0, irq}, 32'h0);
        check("R12 busy", {31'b0, tx_busy}, 32'h0);
        check("R12 cmd", {29'b0, cmd_status}, 32'h0);
        check("R12 push", {31'b0, rxq_push}, 32'h0);

        // table walk: R1 match/ack, R2 no match, R3 start entry
        for (int i = 0; i < 6; i++) begin
            step(1, 0, 0, 8'h00);
            step(0, 0, 1, VEC[i][9:2]);
            check(VEC[i][1] ? "R1 ack" : "R2 no ack", {31'b0, addr_ack}, {31'b0, VEC[i][1]});
            check(VEC[i][0] ? "R3 push" : "R2 no push", {31'b0, rxq_push}, {31'b0, VEC[i][0]});
            if (VEC[i][0]) check("R3 word", rxq_word, {2'b01, 22'd0, VEC[i][9:2]});
            step(0, 1, 0, 8'h00);
            clear_all();
        end

        // write flow R3/R4
        step(1, 0, 0, 8'h00);
        step(0, 0, 1, 8'h20);
        check("R4 rx event", int_status, 32'h0100_0000);
        step(0, 0, 1, 8'hA5);
        check("R4 data1", rxq_word, 32'h8000_00A5);
        step(0, 0, 1, 8'h3C);
        check("R4 data2", {31'b0, rxq_push}, 32'h1);
        check("R4 data2 word", rxq_word, 32'h8000_003C);
        step(0, 1, 0, 8'h00);
        check("R4 end word", rxq_word, 32'hC000_0000);
        check("R4 end push", {31'b0, rxq_push}, 32'h1);
        check("R4 stop bit", int_status, 32'h0180_0000);

        // R11 irq
        int_en = 32'h0080_0000; #1;
        check("R11 irq on", {31'b0, irq}, 32'h1);
        int_en = 32'h0040_0000; #1;
        check("R11 irq off", {31'b0, irq}, 32'h0);
        int_en = '0;

        // R10 write-1-clear and set-wins
        int_clr = 32'h0100_0000; idle(); int_clr = '0;
        check("R10 clear", int_status, 32'h0080_0000);
        step(1, 0, 0, 8'h00);
        int_clr = 32'h0100_0000;
        step(0, 0, 1, 8'h20);
        int_clr = '0;
        check("R10 set wins", int_status & 32'h0100_0000, 32'h0100_0000);
        step(0, 1, 0, 8'h00);
        clear_all();

        // R9 queue levels
        rxq_full = 1; idle(); rxq_full = 0; idle();
        check("R9 full sticky", int_status, 32'h0400_0000);
        rxq_thld = 1; idle(); rxq_thld = 0; idle();
        check("R9 thld sticky", int_status, 32'h0600_0000);
        clear_all();

        // R2 bytes after unmatched address are ignored
        step(1, 0, 0, 8'h00);
        step(0, 0, 1, 8'h44);
        step(0, 0, 1, 8'h55);
        check("R2 byte ignored", {31'b0, rxq_push}, 32'h0);
        step(0, 1, 0, 8'h00);
        check("R2 stop ignored", {31'b0, rxq_push}, 32'h0);
        check("R2 no status", int_status, 32'h0);

        // read flow R5/R6/R7
        step(1, 0, 0, 8'h00);
        step(0, 0, 1, 8'h21);
        check("R5 read event", int_status, 32'h0020_0000);
        check("R5 no push", {31'b0, rxq_push}, 32'h0);
        tx_load = 1; tx_byte = 8'h9C; idle(); tx_load = 0;
        check("R6 busy", {31'b0, tx_busy}, 32'h1);
        tx_req = 1; idle(); tx_req = 0;
        check("R6 valid", {31'b0, tx_valid}, 32'h1);
        check("R6 data", {24'b0, tx_data}, 32'h9C);
        check("R6 busy clear", {31'b0, tx_busy}, 32'h0);
        tx_req = 1; idle(); tx_req = 0;
        check("R7 underrun", int_status & 32'h0040_0000, 32'h0040_0000);
        check("R6 no serve empty", {31'b0, tx_valid}, 32'h0);
        tx_load = 1; tx_byte = 8'h11; idle(); tx_load = 0;
        idle();
        check("R6 late valid", {31'b0, tx_valid}, 32'h1);
        check("R6 late data", {24'b0, tx_data}, 32'h11);
        step(0, 1, 0, 8'h00);
        check("R4 stop on read", int_status & 32'h0080_0000, 32'h0080_0000);
        clear_all();

        // first request: no underrun; stretch timeout R8
        step(1, 0, 0, 8'h00);
        step(0, 0, 1, 8'h21);
        tx_req = 1; idle(); tx_req = 0;
        check("R7 first no underrun", int_status & 32'h0040_0000, 32'h0);
        idle(); idle();
        check("R8 still ok", {29'b0, cmd_status}, 32'd0);
        repeat (10) idle();
        check("R8 timeout", {29'b0, cmd_status}, 32'd5);
        step(1, 0, 0, 8'h00);
        step(0, 0, 1, 8'h21);
        check("R8 reset on address", {29'b0, cmd_status}, 32'd0);
        step(0, 1, 0, 8'h00);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule